// File: doc/BRIEF.md
# Two-Wire Serial Slave Bus Engine

This block is the slave side of a two-wire serial bus. It runs on a system clock that is much faster than the bus clock and oversamples the clock line and the data line. It finds start and stop conditions and shifts bytes in most significant bit first. It compares the first byte of each transfer with a fixed device type and a pin-strapped select code. It drives acknowledges and read data through an open-drain pull-down control. Received bytes go to a memory sequencer through a one-cycle valid strobe, and the sequencer may refuse a byte. Read bytes are requested from the sequencer with a one-cycle request strobe.

A stop that ends a write in which at least one data byte was accepted starts an internal write cycle. Its length is a parameter given in system clock cycles. While that cycle runs, or while the external busy input is high, the engine does not answer its address and leaves SDA released. A master can therefore poll with address bytes and learn from the returned acknowledge when the cycle has finished.

The controller has nine states. IDLE waits for a start. ADDR shifts in the address byte. It moves to ADDR_ACK on a match and back to IDLE otherwise. ADDR_ACK pulls SDA low at the falling SCL edge that follows the eighth bit and then hands over to ACK_HOLD. ACK_HOLD releases SDA at the next falling edge, or drives the first read bit instead. It then enters WR_BYTE or RD_BYTE, depending on the direction bit. WR_BYTE shifts a byte in and moves to WR_ACK. WR_ACK goes to ACK_HOLD if the sequencer accepts the byte and to IDLE if it refuses it. RD_BYTE shifts a byte out and moves to RD_REL, which releases SDA. RD_REL moves to RD_MACK. RD_MACK samples the master's acknowledge. A low level leads to ACK_HOLD and the next byte. A high level leads to IDLE. A stop from any state leads to IDLE. A start from any state leads to ADDR.

Top module: `twi_slave_engine`

## Requirements
- R1: After reset, sda_drive_o, wr_cycle_o, rx_valid_o and rd_req_o are all low.
- R2: An address byte equal to binary 1010 followed by sel_i[2:0] (most significant first) and then a direction bit (0 = write, 1 = read) is acknowledged by SDA held low through the ninth SCL high phase. sda_drive_o changes only while the synchronised SCL is low.
- R3: An address byte whose upper seven bits differ from the expected value gets no acknowledge. Later bytes up to the next start get no acknowledge and produce no rx_valid_o.
- R4: Every byte received after a matched write address appears on rx_data_o, most significant bit first on the bus, with a one-cycle rx_valid_o strobe. It is acknowledged when rx_accept_i is high at the falling SCL edge that follows the eighth bit.
- R5: A byte refused by rx_accept_i low gets no acknowledge. Later bytes up to the next start are neither acknowledged nor presented on rx_valid_o.
- R6: After a matched read address, and after each master acknowledge, rd_req_o strobes once. The engine then sends rd_data_i, most significant bit first, sampled at the next falling SCL edge.
- R7: When the master does not acknowledge a read byte, the engine stops issuing rd_req_o and keeps SDA released until the next start.
- R8: A stop that ends a write with at least one accepted data byte raises wr_cycle_o for exactly WR_CYCLES system clocks. A write with no accepted data byte starts no write cycle.
- R9: While wr_cycle_o or busy_i is high, a matching address gets no acknowledge, and sda_drive_o stays low for the whole write cycle.
- R10: A start in the middle of a byte abandons that byte and begins a new address reception. A read address that follows is served normally.
- R11: frame_start_o and frame_stop_o strobe once for each start and each stop condition on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_o | output | 1 | 1 pulls SDA low (open drain) |
| sel_i | input | 3 | Pin-strapped select code |
| busy_i | input | 1 | External busy; suppresses address acknowledge |
| frame_start_o | output | 1 | Strobe on start condition |
| frame_stop_o | output | 1 | Strobe on stop condition |
| rx_valid_o | output | 1 | Strobe: received byte on rx_data_o |
| rx_data_o | output | 8 | Last received byte |
| rx_accept_i | input | 1 | Sequencer accepts the current byte |
| rd_req_o | output | 1 | Strobe: next read byte requested |
| rd_data_i | input | 8 | Read byte from the sequencer |
| wr_cycle_o | output | 1 | Internal write cycle in progress |

## Verification
The hardest state to reach is a start that arrives while a byte is half shifted in. It is reached by a master task that clocks only four data bits after an acknowledged write address and then raises SDA and SCL to form a repeated start. A read address and a read byte follow. Acknowledge polling is also awkward, because it needs an address byte to arrive while the write cycle timer is still running. The bench therefore sets a write cycle long enough to cover a complete address byte, sends one straight after the committing stop, and then measures the length of the busy window.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_ACK_HOLD,
        ST_RD_BYTE,
        ST_RD_REL,
        ST_RD_MACK
    } twi_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    // SDA edge while SCL stays high on both samples
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/twi_wcycle_timer.sv
module twi_wcycle_timer #(
    parameter int unsigned CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_i) begin
            remain_q <= CW'(CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);

    // A commit can only come from a transfer the slave acknowledged,
    // which never happens while a cycle is running.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
    import twi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WR_CYCLES   = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_o,
    input  logic [2:0] sel_i,
    input  logic       busy_i,
    output logic       frame_start_o,
    output logic       frame_stop_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic       rx_accept_i,
    output logic       rd_req_o,
    input  logic [7:0] rd_data_i,
    output logic       wr_cycle_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    logic scl_w, sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_w),
        .sda_o      (sda_w),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    logic commit_q;
    logic cycle_busy_w;

    twi_wcycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_q),
        .busy_o  (cycle_busy_w)
    );

    twi_state_e           state_q, state_d;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [BYTE_BITS-1:0] shift_q;
    logic                 rw_q;
    logic                 drive_q;
    logic                 wr_seen_q;
    logic                 rx_valid_q;
    logic [BYTE_BITS-1:0] rx_data_q;
    logic                 rd_req_q;

    logic [BYTE_BITS-1:0] byte_in;
    logic                 last_bit;
    logic                 addr_hit;

    assign byte_in  = {shift_q[BYTE_BITS-2:0], sda_w};
    assign last_bit = (bit_cnt_q == LAST_BIT);
    assign addr_hit = (byte_in[7:1] == {DEV_TYPE, sel_i}) && !cycle_busy_w && !busy_i;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        if (stop_w) begin
            state_d = ST_IDLE;
        end else if (start_w) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     ;
                ST_ADDR:     if (scl_rise_w && last_bit) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall_w) state_d = ST_ACK_HOLD;
                ST_WR_BYTE:  if (scl_rise_w && last_bit) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall_w) state_d = rx_accept_i ? ST_ACK_HOLD : ST_IDLE;
                ST_ACK_HOLD: if (scl_fall_w) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_rise_w && last_bit) state_d = ST_RD_REL;
                ST_RD_REL:   if (scl_fall_w) state_d = ST_RD_MACK;
                ST_RD_MACK:  if (scl_rise_w) state_d = sda_w ? ST_IDLE : ST_ACK_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            rw_q       <= 1'b0;
            drive_q    <= 1'b0;
            wr_seen_q  <= 1'b0;
            commit_q   <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
            rd_req_q   <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            rd_req_q   <= 1'b0;
            commit_q   <= 1'b0;
            if (stop_w) begin
                drive_q   <= 1'b0;
                commit_q  <= wr_seen_q;
                wr_seen_q <= 1'b0;
            end else if (start_w) begin
                drive_q   <= 1'b0;
                bit_cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise_w) begin
                            shift_q   <= byte_in;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (last_bit) begin
                                if (state_q == ST_WR_BYTE) begin
                                    rx_valid_q <= 1'b1;
                                    rx_data_q  <= byte_in;
                                end else if (addr_hit) begin
                                    rw_q     <= byte_in[0];
                                    rd_req_q <= byte_in[0];
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall_w) drive_q <= 1'b1;
                    end
                    ST_WR_ACK: begin
                        if (scl_fall_w && rx_accept_i) begin
                            drive_q   <= 1'b1;
                            wr_seen_q <= 1'b1;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (scl_fall_w) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                shift_q <= rd_data_i;
                                drive_q <= ~rd_data_i[BYTE_BITS-1];
                            end else begin
                                drive_q <= 1'b0;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise_w) bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (scl_fall_w) begin
                            shift_q <= {shift_q[BYTE_BITS-2:0], 1'b0};
                            drive_q <= ~shift_q[BYTE_BITS-2];
                        end
                    end
                    ST_RD_REL: begin
                        if (scl_fall_w) drive_q <= 1'b0;
                    end
                    ST_RD_MACK: begin
                        if (scl_rise_w && !sda_w) rd_req_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drive_o   = drive_q;
    assign frame_start_o = start_w;
    assign frame_stop_o  = stop_w;
    assign rx_valid_o    = rx_valid_q;
    assign rx_data_o     = rx_data_q;
    assign rd_req_o      = rd_req_q;
    assign wr_cycle_o    = cycle_busy_w;

    // ---------------- assertions ----------------
    assert_quiet_in_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cycle_o |-> !sda_drive_o);

    assert_drive_on_low_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_o) |-> !scl_w);

    assert_rx_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(scl_rise_w));

    assert_req_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> $past(scl_rise_w));

endmodule

// File: tb/twi_slave_engine_test.sv
module twi_slave_engine_test;

    localparam int unsigned WRC = 1500;
    localparam int HP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_drive_o;
    logic [2:0] sel_i = 3'b101;
    logic       busy_i = 1'b0;
    logic       frame_start_o, frame_stop_o;
    logic       rx_valid_o;
    logic [7:0] rx_data_o;
    logic       rx_accept_i = 1'b1;
    logic       rd_req_o;
    logic [7:0] rd_data_i;
    logic       wr_cycle_o;
    wire        sda_bus = m_sda & ~sda_drive_o;

    always #2.5 clk = ~clk;

    twi_slave_engine #(.WR_CYCLES(WRC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (m_scl),
        .sda_i         (sda_bus),
        .sda_drive_o   (sda_drive_o),
        .sel_i         (sel_i),
        .busy_i        (busy_i),
        .frame_start_o (frame_start_o),
        .frame_stop_o  (frame_stop_o),
        .rx_valid_o    (rx_valid_o),
        .rx_data_o     (rx_data_o),
        .rx_accept_i   (rx_accept_i),
        .rd_req_o      (rd_req_o),
        .rd_data_i     (rd_data_i),
        .wr_cycle_o    (wr_cycle_o)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    logic [7:0] exp_q[$];

    function automatic logic [7:0] rd_val(int k);
        return 8'(k * 29) ^ 8'h5A;
    endfunction

    int rd_ptr = 0;
    assign rd_data_i = rd_val(rd_ptr);

    int starts = 0, stops = 0, cyc_rises = 0, run_len = 0, last_len = 0;
    logic cyc_prev = 1'b0;

    always @(negedge clk) begin
        if (rd_req_o) rd_ptr++;
        if (frame_start_o) starts++;
        if (frame_stop_o) stops++;
        if (wr_cycle_o && !cyc_prev) cyc_rises++;
        if (wr_cycle_o) run_len++;
        else if (run_len != 0) begin last_len = run_len; run_len = 0; end
        cyc_prev = wr_cycle_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected bytes as the design presents them
    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3/R5 unexpected rx_valid", rx_data_o, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data_o == e, "R4 rx byte", rx_data_o, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clock(input logic b, output logic seen);
        m_sda = b;   tick(HP/2);
        m_scl = 1'b1; tick(HP/2);
        seen = sda_bus; tick(HP/2);
        m_scl = 1'b0; tick(HP/2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP/2);
        m_scl = 1'b1; tick(HP/2);
        m_sda = 1'b0; tick(HP/2);
        m_scl = 1'b0; tick(HP/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HP/2);
        m_scl = 1'b1; tick(HP/2);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clock(b[i], s);
        bit_clock(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clock(1'b1, s);
            b[i] = s;
        end
        bit_clock(!mack, s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            summary();
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        logic s;
        tick(10);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk(!sda_drive_o && !wr_cycle_o && !rx_valid_o && !rd_req_o, "R1 reset outputs",
            {sda_drive_o, wr_cycle_o, rx_valid_o, rd_req_o}, 0);

        // R2 / R4 / R8: write two bytes
        bus_start();
        send_byte(8'hAA, a); chk(a == 1'b0, "R2 address ack", a, 0);
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, a); chk(a == 1'b0, "R4 data ack 1", a, 0);
        exp_q.push_back(8'hC3);
        send_byte(8'hC3, a); chk(a == 1'b0, "R4 data ack 2", a, 0);
        bus_stop();
        tick(2);
        chk(wr_cycle_o == 1'b1, "R8 cycle started", wr_cycle_o, 1);

        // R9: acknowledge polling during the cycle
        bus_start();
        send_byte(8'hAA, a); chk(a == 1'b1, "R9 no ack while cycling", a, 1);
        bus_stop();
        for (int i = 0; i < 4000 && wr_cycle_o; i++) tick(1);
        tick(2);
        chk(last_len == WRC, "R8 cycle length", last_len, WRC);
        chk(cyc_rises == 1, "R8 one cycle", cyc_rises, 1);

        // R9: external busy
        busy_i = 1'b1;
        bus_start();
        send_byte(8'hAA, a); chk(a == 1'b1, "R9 no ack while busy_i", a, 1);
        bus_stop();
        busy_i = 1'b0;

        // R3: select mismatch, then type mismatch
        bus_start();
        send_byte(8'hA0, a); chk(a == 1'b1, "R3 select mismatch nack", a, 1);
        send_byte(8'h55, a); chk(a == 1'b1, "R3 following byte ignored", a, 1);
        bus_stop();
        bus_start();
        send_byte(8'hBA, a); chk(a == 1'b1, "R3 type mismatch nack", a, 1);
        bus_stop();

        // R5: sequencer refuses
        rx_accept_i = 1'b0;
        bus_start();
        send_byte(8'hAA, a); chk(a == 1'b0, "R2 address ack before refusal", a, 0);
        exp_q.push_back(8'h77);
        send_byte(8'h77, a); chk(a == 1'b1, "R5 refused byte nack", a, 1);
        send_byte(8'h88, a); chk(a == 1'b1, "R5 later byte ignored", a, 1);
        bus_stop();
        rx_accept_i = 1'b1;
        tick(20);
        chk(cyc_rises == 1 && !wr_cycle_o, "R8 no cycle without accepted data", cyc_rises, 1);

        // R6 / R7: sequential read, master nack on the third byte
        bus_start();
        send_byte(8'hAB, a); chk(a == 1'b0, "R2 read address ack", a, 0);
        recv_byte(1'b1, d); chk(d == rd_val(1), "R6 read byte 1", d, rd_val(1));
        recv_byte(1'b1, d); chk(d == rd_val(2), "R6 read byte 2", d, rd_val(2));
        recv_byte(1'b0, d); chk(d == rd_val(3), "R6 read byte 3", d, rd_val(3));
        recv_byte(1'b1, d); chk(d == 8'hFF, "R7 bus released after nack", d, 8'hFF);
        chk(rd_ptr == 3, "R7 no request after nack", rd_ptr, 3);
        bus_stop();

        // R10: repeated start in mid byte
        bus_start();
        send_byte(8'hAA, a); chk(a == 1'b0, "R10 first address ack", a, 0);
        bit_clock(1'b1, s); bit_clock(1'b0, s); bit_clock(1'b1, s); bit_clock(1'b0, s);
        bus_start();
        send_byte(8'hAB, a); chk(a == 1'b0, "R10 address after repeated start", a, 0);
        recv_byte(1'b0, d); chk(d == rd_val(4), "R10 read after repeated start", d, rd_val(4));
        bus_stop();
        tick(10);

        chk(starts == 9, "R11 start count", starts, 9);
        chk(stops == 8, "R11 stop count", stops, 8);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        chk(cyc_rises == 1, "R8 no cycle from partial byte", cyc_rises, 1);

        done = 1;
        summary();
    end

endmodule